// File: doc/BRIEF.md
# MESI Line State Controller

This block keeps the coherence state of every line in one private cache that sits on a shared snooping bus. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. The block takes requests from the local processor side (read, write, evict) and observations from the bus side (another cache reading, writing or upgrading a line). For each one it updates the line's state, answers snoops with Shared or Dirty, and asks for a write-back when a dirty line has to be flushed.

When the local side misses, or writes to a line it does not own alone, the block holds a single outstanding bus request until the bus reports completion. At completion it samples the wired Shared response. A read fill then lands in Exclusive when no other cache claimed a copy, so a later write to that line changes the state with no bus traffic. If another cache answers Dirty at completion, the request is dropped and tried again after that cache has written its data back.

Tag lookup, the data arrays, arbitration and memory are outside this block. The line index on each interface stands in for a tag match that has already been resolved.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset, every line reads Invalid on `st_vec`. The encoding is I=0, S=1, E=2, M=3, with line n at bits [2n+1:2n]. No bus request is pending and `loc_ready` is 1.
- R2: A local read (`loc_op`=0) of an Invalid line drives `bus_req_valid` with `bus_req_op`=0 (read) from the next cycle. `loc_done` pulses in the cycle of a clean `bus_done`. The line then becomes Shared if `bus_shared_in` was 1 in that cycle, and Exclusive otherwise.
- R3: A local write (`loc_op`=1) of an Invalid line requests `bus_req_op`=1 (write) and ends in Modified.
- R4: A local write of a Shared line requests `bus_req_op`=2 (upgrade) and ends in Modified. A local write of an Exclusive line becomes Modified with no bus request, and `loc_done` pulses in the accepting cycle. Local reads of S, E or M lines and local writes of M lines finish in the accepting cycle with no bus request.
- R5: A snooped bus read (`snp_op`=0) of a Shared line raises `snp_shared` and keeps Shared. For an Exclusive line it raises `snp_shared` and moves to Shared. For a Modified line it raises `snp_dirty` and `snp_wb` and moves to Shared.
- R6: A snooped bus write (`snp_op`=1) moves S or E to Invalid. For a Modified line it also raises `snp_dirty` and `snp_wb` and moves to Invalid. A snooped upgrade (`snp_op`=2) moves Shared to Invalid.
- R7: A snoop of an Invalid line raises no response and leaves the line Invalid.
- R8: A snooped upgrade of an Exclusive or Modified line raises `snp_err` in that cycle and leaves the state unchanged.
- R9: A local eviction (`loc_op`=2) makes the line Invalid and finishes in the accepting cycle. If the line was Modified, `evict_wb` is 1 with `evict_wb_idx` equal to the line in that cycle; otherwise `evict_wb` is 0.
- R10: A `bus_done` with `bus_dirty_in`=1 abandons the attempt. The request stays asserted with the same op and index, the state does not change and `loc_done` stays 0 until a later clean completion.
- R11: When a snoop and an accepted local request hit the same line in one cycle, the snoop is applied first and the local request acts on the state the snoop left.
- R12: If a snoop invalidates a line while its upgrade request is pending, the pending op changes to write (`bus_req_op`=1) from the next cycle, and completion still ends in Modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local request present |
| loc_op | input | 2 | Local request: 0 read, 1 write, 2 evict |
| loc_idx | input | IDX_W | Line addressed by the local request |
| loc_ready | output | 1 | No bus request outstanding; a local request is accepted |
| loc_done | output | 1 | Local request finished this cycle |
| snp_valid | input | 1 | Snooped bus event present |
| snp_op | input | 2 | Snooped event: 0 read, 1 write, 2 upgrade |
| snp_idx | input | IDX_W | Line hit by the snoop |
| snp_shared | output | 1 | Shared response to the snoop |
| snp_dirty | output | 1 | Dirty response to the snoop |
| snp_wb | output | 1 | Write back the snooped line |
| snp_err | output | 1 | Illegal snoop for the line's state |
| bus_req_valid | output | 1 | Bus request outstanding |
| bus_req_op | output | 2 | Request: 0 read, 1 write, 2 upgrade |
| bus_req_idx | output | IDX_W | Line of the outstanding request |
| bus_done | input | 1 | Outstanding request completes this cycle |
| bus_shared_in | input | 1 | Wired Shared response, sampled at completion |
| bus_dirty_in | input | 1 | Wired Dirty response; abandons this attempt |
| evict_wb | output | 1 | Eviction needs a write-back |
| evict_wb_idx | output | IDX_W | Line to write back on eviction |
| st_vec | output | 2*NUM_LINES | State of every line |

## Verification
The hardest situation to reach is a pending upgrade whose line is invalidated by a snooped write before the bus grants it. To get there, the bench first fills a line as Exclusive. In one cycle it then issues a local write and a snooped read to that same line, which proves snoop-first ordering: the write sees Shared and starts an upgrade. While `bus_done` is held low it then snoops a bus write to that line, and expects the request to turn into a write and complete as Modified. A Dirty abort is reached by pulsing `bus_done` together with `bus_dirty_in` once before the clean completion.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {LOC_RD = 2'd0, LOC_WR = 2'd1, LOC_EV = 2'd2} loc_op_e;
  typedef enum logic [1:0] {BUS_RD = 2'd0, BUS_WR = 2'd1, BUS_UP = 2'd2} bus_op_e;

  typedef struct packed {
    logic     shared;
    logic     dirty;
    logic     wb;
    logic     err;
    line_st_e nxt;
  } snp_res_t;

  // Reaction of a line to a bus event seen from another cache.
  function automatic snp_res_t snoop_react(line_st_e cur, bus_op_e op);
    snp_res_t r;
    r.shared = 1'b0;
    r.dirty  = 1'b0;
    r.wb     = 1'b0;
    r.err    = 1'b0;
    r.nxt    = cur;
    case (cur)
      ST_S: begin
        if (op == BUS_RD) r.shared = 1'b1;
        else if (op == BUS_WR || op == BUS_UP) r.nxt = ST_I;
      end
      ST_E: begin
        if (op == BUS_RD) begin r.shared = 1'b1; r.nxt = ST_S; end
        else if (op == BUS_WR) r.nxt = ST_I;
        else if (op == BUS_UP) r.err = 1'b1;
      end
      ST_M: begin
        if (op == BUS_RD) begin r.dirty = 1'b1; r.wb = 1'b1; r.nxt = ST_S; end
        else if (op == BUS_WR) begin r.dirty = 1'b1; r.wb = 1'b1; r.nxt = ST_I; end
        else if (op == BUS_UP) r.err = 1'b1;
      end
      default: ;
    endcase
    return r;
  endfunction

  // State a line takes when its own bus request completes cleanly.
  function automatic line_st_e fill_state(bus_op_e op, logic shared_seen);
    if (op == BUS_RD) return shared_seen ? ST_S : ST_E;
    return ST_M;
  endfunction
endpackage

// File: rtl/mesi_snoop_unit.sv
`timescale 1ns/1ps
module mesi_snoop_unit
  import mesi_pkg::*;
(
  input  logic       snp_valid,
  input  logic [1:0] snp_op,
  input  line_st_e   cur_st,
  output snp_res_t   res
);
  snp_res_t idle_res;

  always_comb begin
    idle_res        = '0;
    idle_res.nxt    = cur_st;
    res = snp_valid ? snoop_react(cur_st, bus_op_e'(snp_op)) : idle_res;
  end
endmodule

// File: rtl/mesi_state_store.sv
`timescale 1ns/1ps
module mesi_state_store
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int SW = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snp_en,
  input  logic [IDX_W-1:0]        snp_idx,
  input  line_st_e                snp_nxt,
  input  logic                    ld_en,
  input  logic [IDX_W-1:0]        ld_idx,
  input  line_st_e                ld_st,
  output logic [NUM_LINES*SW-1:0] st_vec
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_st_e st_q;
    // Local load wins: it was already computed from the post-snoop state.
    always_ff @(posedge clk) begin
      if (!rst_n)                                st_q <= ST_I;
      else if (ld_en && ld_idx == IDX_W'(g))     st_q <= ld_st;
      else if (snp_en && snp_idx == IDX_W'(g))   st_q <= snp_nxt;
    end
    assign st_vec[g*SW +: SW] = st_q;
  end
endmodule

// File: rtl/mesi_local_seq.sv
`timescale 1ns/1ps
module mesi_local_seq
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loc_valid,
  input  logic [1:0]       loc_op,
  input  logic [IDX_W-1:0] loc_idx,
  input  line_st_e         post_st,
  input  logic             bus_done,
  input  logic             bus_shared_in,
  input  logic             bus_dirty_in,
  output logic [IDX_W-1:0] cur_idx,
  output logic             loc_ready,
  output logic             loc_done,
  output logic             bus_req_valid,
  output logic [1:0]       bus_req_op,
  output logic [IDX_W-1:0] bus_req_idx,
  output logic             ld_en,
  output logic [IDX_W-1:0] ld_idx,
  output line_st_e         ld_st,
  output logic             evict_wb,
  output logic [IDX_W-1:0] evict_wb_idx
);
  logic             busy_q;
  bus_op_e          pop_q, eff_op, start_op;
  logic [IDX_W-1:0] pidx_q;
  logic             accept, start, finish;

  assign cur_idx   = busy_q ? pidx_q : loc_idx;
  assign accept    = !busy_q && loc_valid;
  assign finish    = busy_q && bus_done && !bus_dirty_in;
  // An upgrade whose copy was snooped away becomes a full write miss.
  assign eff_op    = (pop_q == BUS_UP && post_st == ST_I) ? BUS_WR : pop_q;

  always_comb begin
    start    = 1'b0;
    start_op = BUS_RD;
    loc_done = 1'b0;
    ld_en    = 1'b0;
    ld_idx   = loc_idx;
    ld_st    = post_st;
    evict_wb = 1'b0;
    if (accept) begin
      case (loc_op_e'(loc_op))
        LOC_RD: begin
          if (post_st == ST_I) begin start = 1'b1; start_op = BUS_RD; end
          else loc_done = 1'b1;
        end
        LOC_WR: begin
          case (post_st)
            ST_I: begin start = 1'b1; start_op = BUS_WR; end
            ST_S: begin start = 1'b1; start_op = BUS_UP; end
            ST_E: begin ld_en = 1'b1; ld_st = ST_M; loc_done = 1'b1; end
            default: loc_done = 1'b1;
          endcase
        end
        LOC_EV: begin
          ld_en    = 1'b1;
          ld_st    = ST_I;
          evict_wb = (post_st == ST_M);
          loc_done = 1'b1;
        end
        default: ;
      endcase
    end
    if (finish) begin
      ld_en    = 1'b1;
      ld_idx   = pidx_q;
      ld_st    = fill_state(eff_op, bus_shared_in);
      loc_done = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pop_q  <= BUS_RD;
      pidx_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      pop_q  <= start_op;
      pidx_q <= loc_idx;
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      pop_q  <= eff_op;
    end
  end

  assign loc_ready     = !busy_q;
  assign bus_req_valid = busy_q;
  assign bus_req_op    = pop_q;
  assign bus_req_idx   = pidx_q;
  assign evict_wb_idx  = loc_idx;

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !(bus_done && !bus_dirty_in)) |=> (bus_req_valid && $stable(bus_req_idx)));

  p_upgrade_conv_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_op == 2'd2 && post_st == ST_I && !bus_done) |=> (bus_req_op == 2'd1));

  p_silent_upgrade_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && loc_ready && loc_op == 2'd1 && post_st == ST_E) |=> !bus_req_valid);
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int SW = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loc_valid,
  input  logic [1:0]              loc_op,
  input  logic [IDX_W-1:0]        loc_idx,
  output logic                    loc_ready,
  output logic                    loc_done,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_op,
  input  logic [IDX_W-1:0]        snp_idx,
  output logic                    snp_shared,
  output logic                    snp_dirty,
  output logic                    snp_wb,
  output logic                    snp_err,
  output logic                    bus_req_valid,
  output logic [1:0]              bus_req_op,
  output logic [IDX_W-1:0]        bus_req_idx,
  input  logic                    bus_done,
  input  logic                    bus_shared_in,
  input  logic                    bus_dirty_in,
  output logic                    evict_wb,
  output logic [IDX_W-1:0]        evict_wb_idx,
  output logic [NUM_LINES*SW-1:0] st_vec
);
  line_st_e         st_arr [NUM_LINES];
  snp_res_t         snp_res;
  line_st_e         post_st;
  logic [IDX_W-1:0] cur_idx;
  logic             ld_en;
  logic [IDX_W-1:0] ld_idx;
  line_st_e         ld_st;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_unpack
    assign st_arr[g] = line_st_e'(st_vec[g*SW +: SW]);
  end

  mesi_snoop_unit u_snoop (
    .snp_valid (snp_valid),
    .snp_op    (snp_op),
    .cur_st    (st_arr[snp_idx]),
    .res       (snp_res)
  );

  // Snoop-first: the local side sees the state the snoop leaves behind.
  assign post_st = (snp_valid && snp_idx == cur_idx) ? snp_res.nxt : st_arr[cur_idx];

  mesi_local_seq #(.NUM_LINES(NUM_LINES)) u_local (
    .clk           (clk),
    .rst_n         (rst_n),
    .loc_valid     (loc_valid),
    .loc_op        (loc_op),
    .loc_idx       (loc_idx),
    .post_st       (post_st),
    .bus_done      (bus_done),
    .bus_shared_in (bus_shared_in),
    .bus_dirty_in  (bus_dirty_in),
    .cur_idx       (cur_idx),
    .loc_ready     (loc_ready),
    .loc_done      (loc_done),
    .bus_req_valid (bus_req_valid),
    .bus_req_op    (bus_req_op),
    .bus_req_idx   (bus_req_idx),
    .ld_en         (ld_en),
    .ld_idx        (ld_idx),
    .ld_st         (ld_st),
    .evict_wb      (evict_wb),
    .evict_wb_idx  (evict_wb_idx)
  );

  mesi_state_store #(.NUM_LINES(NUM_LINES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .snp_en  (snp_valid),
    .snp_idx (snp_idx),
    .snp_nxt (snp_res.nxt),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_st   (ld_st),
    .st_vec  (st_vec)
  );

  assign snp_shared = snp_res.shared;
  assign snp_dirty  = snp_res.dirty;
  assign snp_wb     = snp_res.wb;
  assign snp_err    = snp_res.err;

  p_err_keeps_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_err && !(ld_en && ld_idx == snp_idx))
      |=> (st_arr[$past(snp_idx)] == $past(st_arr[snp_idx])));

  p_dirty_leaves_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_dirty) |=> (st_arr[$past(snp_idx)] != ST_M));

  p_evict_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && loc_ready && loc_op == 2'd2) |=> (st_arr[$past(loc_idx)] == ST_I));

  p_no_resp_on_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && st_arr[snp_idx] == ST_I) |-> !(snp_shared || snp_dirty || snp_err));
endmodule

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb;
  localparam int NL = 4;
  localparam int IW = 2;
  localparam int K_ST = 0, K_REQ = 1, K_SNP = 2, K_DONE = 3, K_EWB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic loc_valid = 0, snp_valid = 0, bus_done = 0, bus_shared_in = 0, bus_dirty_in = 0;
  logic [1:0] loc_op = 0, snp_op = 0;
  logic [IW-1:0] loc_idx = 0, snp_idx = 0;
  logic loc_ready, loc_done, snp_shared, snp_dirty, snp_wb, snp_err;
  logic bus_req_valid, evict_wb;
  logic [1:0] bus_req_op;
  logic [IW-1:0] bus_req_idx, evict_wb_idx;
  logic [2*NL-1:0] st_vec;

  mesi_line_ctrl #(.NUM_LINES(NL)) u_dut (.*);

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  typedef struct {int due; int kind; int idx; int exp; string req;} item_t;
  item_t sb[$];

  task automatic expect_at(int kind, int idx, int exp, int off, string req);
    item_t it;
    it.due = cyc + off; it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  function automatic int observe(int kind, int idx);
    case (kind)
      K_ST:   return int'(st_vec[idx*2 +: 2]);
      K_REQ:  return bus_req_valid ? int'({1'b1, bus_req_op, bus_req_idx}) : 0;
      K_SNP:  return int'({snp_shared, snp_dirty, snp_wb, snp_err});
      K_DONE: return int'({loc_ready, loc_done});
      default: return int'({evict_wb, evict_wb_idx});
    endcase
  endfunction

  // Monitor: pops the items due in this cycle and compares them.
  initial begin
    forever begin
      @(negedge clk); #8;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          int a;
          a = observe(sb[i].kind, sb[i].idx);
          checks++;
          if (a !== sb[i].exp) begin
            fails++;
            $display("FAIL %s kind=%0d idx=%0d actual=%0d expected=%0d", sb[i].req,
                     sb[i].kind, sb[i].idx, a, sb[i].exp);
          end
          sb.delete(i);
        end
      end
    end
  end

  task automatic drive(logic lv, logic [1:0] lop, int lidx, logic sv, logic [1:0] sop, int sidx,
                       logic bd, logic bsh, logic bdi);
    @(negedge clk); #1;
    loc_valid = lv; loc_op = lop; loc_idx = IW'(lidx);
    snp_valid = sv; snp_op = sop; snp_idx = IW'(sidx);
    bus_done = bd; bus_shared_in = bsh; bus_dirty_in = bdi;
  endtask

  // Full fill of an Invalid line by a local read.
  task automatic read_fill(int idx, logic sh, string req);
    drive(1, 2'd0, idx, 0, 0, 0, 0, 0, 0);
    expect_at(K_DONE, 0, 2, 0, req);
    expect_at(K_REQ, 0, 16 + idx, 1, req);
    drive(0, 0, 0, 0, 0, 0, 1, sh, 0);
    expect_at(K_DONE, 0, 1, 0, req);
    expect_at(K_ST, idx, sh ? 1 : 2, 1, req);
    expect_at(K_REQ, 0, 0, 1, req);
  endtask

  task automatic snoop(int op, int idx, int resp, int nst, string req);
    drive(0, 0, 0, 1, 2'(op), idx, 0, 0, 0);
    expect_at(K_SNP, 0, resp, 0, req);
    expect_at(K_ST, idx, nst, 1, req);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < NL; i++) expect_at(K_ST, i, 0, 0, "R1");
    expect_at(K_REQ, 0, 0, 0, "R1");
    expect_at(K_DONE, 0, 2, 0, "R1");
    // R2: fill alone -> E, fill with Shared -> S
    read_fill(0, 1'b0, "R2");
    read_fill(1, 1'b1, "R2");
    // R4: silent write E->M, then read hit in M
    drive(1, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    expect_at(K_DONE, 0, 3, 0, "R4");
    expect_at(K_ST, 0, 3, 1, "R4");
    expect_at(K_REQ, 0, 0, 1, "R4");
    drive(1, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    expect_at(K_DONE, 0, 3, 0, "R4");
    expect_at(K_REQ, 0, 0, 1, "R4");
    // R5: snooped reads of M and S lines
    snoop(0, 0, 6, 1, "R5");
    snoop(0, 1, 8, 1, "R5");
    // R10: dirty abort then clean retry on line 2
    drive(1, 2'd0, 2, 0, 0, 0, 0, 0, 0);
    expect_at(K_REQ, 0, 18, 1, "R10");
    drive(0, 0, 0, 0, 0, 0, 1, 1, 1);
    expect_at(K_DONE, 0, 0, 0, "R10");
    expect_at(K_REQ, 0, 18, 1, "R10");
    expect_at(K_ST, 2, 0, 1, "R10");
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
    expect_at(K_DONE, 0, 1, 0, "R10");
    expect_at(K_ST, 2, 2, 1, "R10");
    // R8: upgrade snoop on E line
    snoop(2, 2, 1, 2, "R8");
    // R4: write on S line -> upgrade request -> M
    drive(1, 2'd1, 1, 0, 0, 0, 0, 0, 0);
    expect_at(K_REQ, 0, 25, 1, "R4");
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
    expect_at(K_ST, 1, 3, 1, "R4");
    // R8 on M, R6 write snoop on M, R7 snoop on I
    snoop(2, 1, 1, 3, "R8");
    snoop(1, 1, 6, 0, "R6");
    snoop(0, 1, 0, 0, "R7");
    snoop(1, 2, 0, 0, "R6");
    snoop(2, 0, 0, 0, "R6");
    // R3: write miss
    drive(1, 2'd1, 3, 0, 0, 0, 0, 0, 0);
    expect_at(K_REQ, 0, 23, 1, "R3");
    drive(0, 0, 0, 0, 0, 0, 1, 1, 0);
    expect_at(K_ST, 3, 3, 1, "R3");
    // R9: evict M with write-back, evict E without
    drive(1, 2'd2, 3, 0, 0, 0, 0, 0, 0);
    expect_at(K_EWB, 0, 7, 0, "R9");
    expect_at(K_DONE, 0, 3, 0, "R9");
    expect_at(K_ST, 3, 0, 1, "R9");
    read_fill(2, 1'b0, "R9");
    drive(1, 2'd2, 2, 0, 0, 0, 0, 0, 0);
    expect_at(K_EWB, 0, 2, 0, "R9");
    expect_at(K_ST, 2, 0, 1, "R9");
    // R11: local write and snooped read on the same E line in one cycle
    read_fill(1, 1'b0, "R11");
    drive(1, 2'd1, 1, 1, 2'd0, 1, 0, 0, 0);
    expect_at(K_SNP, 0, 8, 0, "R11");
    expect_at(K_DONE, 0, 2, 0, "R11");
    expect_at(K_ST, 1, 1, 1, "R11");
    expect_at(K_REQ, 0, 25, 1, "R11");
    // R12: pending upgrade invalidated by a snooped write
    drive(0, 0, 0, 1, 2'd1, 1, 0, 0, 0);
    expect_at(K_SNP, 0, 0, 0, "R12");
    expect_at(K_ST, 1, 0, 1, "R12");
    expect_at(K_REQ, 0, 21, 1, "R12");
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
    expect_at(K_DONE, 0, 1, 0, "R12");
    expect_at(K_ST, 1, 3, 1, "R12");
    expect_at(K_REQ, 0, 0, 1, "R12");
    // R4: read hit in S needs no bus
    read_fill(0, 1'b1, "R4");
    drive(1, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    expect_at(K_DONE, 0, 3, 0, "R4");
    expect_at(K_REQ, 0, 0, 1, "R4");
    expect_at(K_ST, 0, 1, 1, "R4");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R1 scoreboard drain actual=%0d expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule